// File: doc/BRIEF.md
# Watchdog Counter with Non-Maskable Interrupt Request

This block watches for runaway software. A slow periodic tick, supplied as a one-cycle enable in the system clock domain (nominally 16 Hz from a time-base divider), advances a 6-bit count. Software must keep clearing that count by writing the watchdog control register with the clear bit set. If it fails to, the count passes its top value and the block raises a non-maskable interrupt request. With 64 ticks at 16 Hz, the timeout is 4 s.

The request is a single-cycle pulse with no enable or mask input in its path. It goes to the interrupt controller as the highest-priority, unmaskable source. After an overflow the count wraps to zero and keeps running, so repeated neglect produces a pulse every 64 ticks. The current count can be read on an output port.

Top module: `wdog_nmi`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes 0 and `nmi_req` becomes 0 (synchronous, active-low reset).
- R2: A `tick_en` pulse with a count below 63 and no clear raises `count` by exactly one at the next clock edge, with `nmi_req` low.
- R3: A `tick_en` pulse with a count of 63 and no clear sets `count` to 0 and drives `nmi_req` high for that one following cycle.
- R4: A control write (`wd_wr` high with `wd_wdata` bit 0 set) makes `count` 0 at the next edge. This holds even when a tick arrives in the same cycle, including at count 63, and in that case `nmi_req` stays low.
- R5: A control write with `wd_wdata` bit 0 clear does not clear the count; any tick in that cycle is counted as if no write happened.
- R6: With no tick and no clear write, `count` holds its value and `nmi_req` is low.
- R7: `nmi_req` is never high in two consecutive cycles, and it has no enable or mask input; after an overflow, counting continues from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base tick enable (16 Hz nominal) |
| wd_wr | input | 1 | Write strobe for the watchdog control register |
| wd_wdata | input | 8 | Write data; bit 0 set requests a clear |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on overflow |
| count | output | 6 | Current watchdog count |

## Verification
Directed runs take the count from 0 through 63 by ticks alone, with no writes. This shows a plain step apart from the wrap and its one pulse. Further directed runs place a clear write and a tick on the same edge, both at 63 and at a mid value, which shows whether the clear outranks the tick. Another run writes with bit 0 low during a tick, which separates a real clear from a write that should do nothing. Random stimulus then mixes ticks, writes with random data and occasional resets. Each cycle is checked against a bench model, so clears, steps, holds and wraps appear in many different orders.

// File: rtl/wdog_nmi_pkg.sv
// Package: shared constants and the per-cycle action type for the watchdog.
// Assumes: the users pass matching widths as parameters.
package wdog_nmi_pkg;

    // Default count width: 64 ticks to overflow.
    localparam int unsigned WD_CNT_W  = 6;
    // Default control data width.
    localparam int unsigned WD_DATA_W = 8;
    // Bit of the control data that requests a clear.
    localparam int unsigned WD_CLR_BIT = 0;

    // What the counter does on the next edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_WRAP  = 2'd3
    } wd_act_e;

endpackage : wdog_nmi_pkg

// File: rtl/wdog_act_decode.sv
// Module: wdog_act_decode
// Turns the tick, the control write and the current count into one action.
// Priority: a clear write beats a tick; a tick at the top value becomes a wrap.
// Assumes: tick_en is a single-cycle enable in the clk domain.
module wdog_act_decode
    import wdog_nmi_pkg::*;
#(
    parameter int unsigned CNT_W   = WD_CNT_W,
    parameter int unsigned DATA_W  = WD_DATA_W,
    parameter int unsigned CLR_BIT = WD_CLR_BIT
) (
    input  logic              tick_en,
    input  logic              wd_wr,
    input  logic [DATA_W-1:0] wd_wdata,
    input  logic [CNT_W-1:0]  cnt_cur,
    output wd_act_e           act
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic clr_req;
    logic unused_wdata;

    // Only the clear bit has meaning; the rest of the data is deliberately ignored.
    assign clr_req      = wd_wr & wd_wdata[CLR_BIT];
    assign unused_wdata = ^wd_wdata;

    // Pick the action with the clear write first, then the tick.
    always_comb begin
        if (clr_req) begin
            act = ACT_CLEAR;
        end else if (tick_en) begin
            act = (cnt_cur == CNT_TOP) ? ACT_WRAP : ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule : wdog_act_decode

// File: rtl/wdog_tick_counter.sv
// Module: wdog_tick_counter
// Holds the watchdog count and applies the decoded action on each edge.
// Assumes: synchronous active-low reset; a wrap returns to zero and keeps going.
module wdog_tick_counter
    import wdog_nmi_pkg::*;
#(
    parameter int unsigned CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_act_e          act,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    // Count register: reset, clear, step, wrap or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else begin
            unique case (act)
                ACT_CLEAR: cnt_q <= CNT_ZERO;
                ACT_STEP:  cnt_q <= cnt_q + CNT_ONE;
                ACT_WRAP:  cnt_q <= CNT_ZERO;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

endmodule : wdog_tick_counter

// File: rtl/wdog_nmi_pulse.sv
// Module: wdog_nmi_pulse
// Registers a one-cycle interrupt request on a wrap action.
// Assumes: wraps cannot occur on two adjacent edges because the count restarts at zero.
module wdog_nmi_pulse
    import wdog_nmi_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wd_act_e act,
    output logic    nmi_q
);

    // Request flop: high for exactly the cycle after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= (act == ACT_WRAP);
        end
    end

endmodule : wdog_nmi_pulse

// File: rtl/wdog_nmi.sv
// Module: wdog_nmi (top)
// Watchdog that counts time-base ticks and pulses an unmaskable interrupt
// request when software does not clear it within 2**CNT_W ticks.
// Assumes: tick_en is a single-cycle enable synchronous to clk.
module wdog_nmi
    import wdog_nmi_pkg::*;
#(
    parameter int unsigned CNT_W   = WD_CNT_W,
    parameter int unsigned DATA_W  = WD_DATA_W,
    parameter int unsigned CLR_BIT = WD_CLR_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wd_wr,
    input  logic [DATA_W-1:0] wd_wdata,
    output logic              nmi_req,
    output logic [CNT_W-1:0]  count
);

    wd_act_e          act;
    logic [CNT_W-1:0] cnt_q;

    // Decide this cycle's action.
    wdog_act_decode #(
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .CLR_BIT (CLR_BIT)
    ) u_decode (
        .tick_en  (tick_en),
        .wd_wr    (wd_wr),
        .wd_wdata (wd_wdata),
        .cnt_cur  (cnt_q),
        .act      (act)
    );

    // Apply it to the count.
    wdog_tick_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .cnt_q (cnt_q)
    );

    // Turn a wrap into the request pulse.
    wdog_nmi_pulse u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .nmi_q (nmi_req)
    );

    assign count = cnt_q;

endmodule : wdog_nmi

// File: rtl/wdog_nmi_chk.sv
// Module: wdog_nmi_chk
// Checker with the port-level properties of the watchdog; bound to wdog_nmi below.
// Assumes: the same parameters as the bound instance.
module wdog_nmi_chk #(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLR_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wd_wr,
    input logic [DATA_W-1:0] wd_wdata,
    input logic              nmi_req,
    input logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic clr_w;
    assign clr_w = wd_wr & wd_wdata[CLR_BIT];

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !nmi_req);  // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !clr_w && count != TOP) |=>
            (count == $past(count) + 1'b1) && !nmi_req);  // R2

    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !clr_w && count == TOP) |=> (count == '0) && nmi_req);  // R3

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (count == '0) && !nmi_req);  // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr_w) |=> $stable(count) && !nmi_req);  // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);  // R7

endmodule : wdog_nmi_chk

bind wdog_nmi wdog_nmi_chk #(
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .CLR_BIT (CLR_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wd_wr    (wd_wr),
    .wd_wdata (wd_wdata),
    .nmi_req  (nmi_req),
    .count    (count)
);

// File: tb/wdog_nmi_tb.sv
// Bench: drives directed corner cases and seeded random stimulus and
// compares every cycle with a model derived from the requirements.
module wdog_nmi_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wd_wr = 1'b0;
    logic [7:0] wd_wdata = 8'h00;
    logic       nmi_req;
    logic [5:0] count;

    int n_chk = 0;
    int n_err = 0;
    logic [5:0] m_cnt = 6'd0;
    logic       m_nmi = 1'b0;
    string      m_tag = "R1";

    always #2.5 clk = ~clk;

    wdog_nmi u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wd_wr    (wd_wr),
        .wd_wdata (wd_wdata),
        .nmi_req  (nmi_req),
        .count    (count)
    );

    // Model: next count from the requirements.
    function automatic logic [5:0] nxt_cnt(logic r, logic t, logic w, logic [7:0] d, logic [5:0] c);
        if (!r) return 6'd0;                 // R1
        if (w && d[0]) return 6'd0;          // R4
        if (t) return (c == 6'd63) ? 6'd0 : c + 6'd1;  // R2, R3, R5
        return c;                            // R6
    endfunction

    // Model: next request value.
    function automatic logic nxt_nmi(logic r, logic t, logic w, logic [7:0] d, logic [5:0] c);
        return r && !(w && d[0]) && t && (c == 6'd63);  // R3, R7
    endfunction

    // Which requirement this cycle exercises.
    function automatic string tag_of(logic r, logic t, logic w, logic [7:0] d, logic [5:0] c);
        if (!r) return "R1";
        if (w && d[0]) return "R4";
        if (w) return "R5";
        if (t && c == 6'd63) return "R3";
        if (t) return "R2";
        return "R6";
    endfunction

    // Apply one cycle of inputs at the falling edge, update the model, check at the next falling edge.
    task automatic cyc(logic r, logic t, logic w, logic [7:0] d);
        logic [5:0] ncnt;
        logic       nnmi;
        rst_n = r; tick_en = t; wd_wr = w; wd_wdata = d;
        ncnt  = nxt_cnt(r, t, w, d, m_cnt);
        nnmi  = nxt_nmi(r, t, w, d, m_cnt);
        m_tag = tag_of(r, t, w, d, m_cnt);
        @(posedge clk);
        m_cnt = ncnt;
        m_nmi = nnmi;
        @(negedge clk);
        n_chk++;
        if (count !== m_cnt || nmi_req !== m_nmi) begin
            n_err++;
            $display("FAIL %s: count=%0d nmi=%0b expected count=%0d nmi=%0b",
                     m_tag, count, nmi_req, m_cnt, m_nmi);
        end
    endtask

    // Watchdog for the bench itself.
    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL R7: bench timeout actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(negedge clk);
        // R1: reset state
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        // R2/R3: 64 ticks reach the wrap and one pulse
        for (int i = 0; i < 64; i++) cyc(1'b1, 1'b1, 1'b0, 8'h00);
        // R7: pulse ends, counting resumes from 0
        cyc(1'b1, 1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);   // R6 hold
        // Climb to 63, then clear together with the tick: R4 priority
        for (int i = 0; i < 62; i++) cyc(1'b1, 1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b1, 1'b1, 8'h01);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        // R5: write with bit 0 low does not clear, tick still counts
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b1, 1'b1, 8'hFE);
        cyc(1'b1, 1'b0, 1'b1, 8'h80);
        // R4: clear with other data bits set, mid count
        cyc(1'b1, 1'b1, 1'b1, 8'hFF);
        // Random mix
        for (int i = 0; i < 20000; i++) begin
            logic r = ($urandom % 400) != 0;
            logic t = ($urandom % 2) == 0;
            logic w = ($urandom % 60) == 0;
            logic [7:0] d = 8'($urandom);
            cyc(r, t, w, d);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule : wdog_nmi_tb